// File: doc/BRIEF.md
# Audio Link Sample FIFO

This block sits between a DMA engine and a serial audio link controller and buffers samples for one transmit stream and one receive stream. On the transmit side the DMA engine writes samples and the link controller pulls one sample per frame slot. Each pulled sample comes back with a valid flag. On the receive side the link controller strobes samples in and the DMA engine drains them. Each direction has its own enable, DMA request, sticky error flag and error-halt control.

The DMA-facing data paths use valid/ready. On transmit, `tx_in_ready` is high only while the stream is enabled and the buffer has room. A beat offered while ready is low is not taken, and the DMA side must hold it. On receive, `rx_out_valid` is high while the stream is enabled and the buffer holds a sample. A beat leaves only in a cycle where `rx_out_ready` is also high. The link side has no back-pressure. A transmit slot request is always answered, and a receive strobe is either stored or dropped.

After the transmit stream is enabled, slot requests are answered as not valid until the buffer has been full once. This builds up the largest possible cushion before samples start to flow. Turning a stream's enable off and back on empties its buffer, clears its error flag and re-arms the transmit prefill.

Top module: `audio_sample_fifo`

## Requirements
- R1: `tx_in_ready` is high exactly when `tx_en` is high and fewer than `TX_DEPTH` samples are held. A write offered while `tx_in_ready` is low is dropped. `tx_dma_req` equals `tx_in_ready` unless error-halt is blocking it (R9).
- R2: When `tx_slot_req` is sampled high and samples are released, the oldest held sample is removed. After that clock edge it appears on `tx_slot_data` with `tx_slot_valid` high. The slot outputs hold their values until the next request.
- R3: After `tx_en` rises, slot requests are answered with `tx_slot_valid` low and zero data, and `tx_underrun` is not set, until the buffer has been full. The first request sampled in a cycle where the buffer is full is served.
- R4: A slot request sampled when samples are released but the buffer is empty gives `tx_slot_valid` low and all-zero data. It also sets `tx_underrun`, which stays high while `tx_en` stays high.
- R5: `rx_out_valid` is high while `rx_en` is high and a sample is held. `rx_out_data` shows the oldest sample. A beat is removed on a clock edge where both `rx_out_valid` and `rx_out_ready` are high. `rx_dma_req` equals `rx_out_valid` unless error-halt is blocking it (R9).
- R6: An `rx_strobe` sampled while `rx_en` is low stores nothing.
- R7: An `rx_strobe` sampled while `RX_DEPTH` samples are held is dropped, even if a beat leaves in the same cycle. It also sets `rx_overrun`, which stays high while `rx_en` stays high.
- R8: A clock edge with a stream's enable low empties that stream's buffer and clears its error flag. For transmit, it also drives the slot outputs to zero and re-arms the R3 prefill.
- R9: When a stream's halt input is high and its error flag is set, its DMA request is low while the data handshake keeps working. With the halt input low, the error flag does not affect the request.
- R10: After reset, every output is low.
- R11: A slot request sampled while `tx_en` is low gives `tx_slot_valid` low and zero data, and does not set `tx_underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit stream enable |
| tx_halt_en | input | 1 | Transmit error-halt mode |
| tx_in_valid | input | 1 | DMA write beat offered |
| tx_in_ready | output | 1 | Transmit buffer accepts a beat |
| tx_in_data | input | W | DMA write sample |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_slot_req | input | 1 | Link asks for the next transmit sample |
| tx_slot_valid | output | 1 | Answered sample is valid |
| tx_slot_data | output | W | Answered sample, zero when not valid |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_en | input | 1 | Receive stream enable |
| rx_halt_en | input | 1 | Receive error-halt mode |
| rx_strobe | input | 1 | Link delivers a receive sample |
| rx_strobe_data | input | W | Delivered receive sample |
| rx_out_valid | output | 1 | Receive beat available |
| rx_out_ready | input | 1 | DMA side takes the beat |
| rx_out_data | output | W | Oldest receive sample |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The bench fills the transmit buffer to its depth while sending slot requests. A design that skips the prefill would hand out samples at once. A design that makes the prefill one cycle late would miss the first request made while the buffer is full. It drains the buffer past empty to check that underrun gives zero data and sets a sticky flag. A design that repeats the last sample or lets the flag clear would fail this. On receive it strobes a sample into a full buffer, once alone and once while a beat leaves in the same cycle. A design that lets a pop make room for the incoming strobe would store the sample instead of dropping it. It also toggles the halt inputs while an error flag is set, and cycles each enable to confirm that the buffer is emptied and the prefill is re-armed.

// File: rtl/asf_pkg.sv
`timescale 1ns/1ps
package asf_pkg;

  // What the transmit side does with a link slot request this cycle
  typedef enum logic [1:0] {
    SLOT_IDLE     = 2'd0,
    SLOT_PREFILL  = 2'd1,
    SLOT_UNDERRUN = 2'd2,
    SLOT_SERVE    = 2'd3
  } slot_act_e;

  // Pointer width for a ring of d entries (at least one bit)
  function automatic int unsigned ptr_w(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

endpackage

// File: rtl/asf_sample_ring.sv
`timescale 1ns/1ps
module asf_sample_ring #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = asf_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rd_q];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (!flush && do_push && wr_q == PW'(i)) begin
        slot_q[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/asf_tx_path.sv
`timescale 1ns/1ps
module asf_tx_path
  import asf_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         halt_en,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         slot_req,
  input  logic [W-1:0] head,
  input  logic         empty,
  input  logic         full,
  output logic         ring_push,
  output logic [W-1:0] ring_wdata,
  output logic         ring_pop,
  output logic         ring_flush,
  output logic         in_ready,
  output logic         dma_req,
  output logic         slot_valid,
  output logic [W-1:0] slot_data,
  output logic         underrun
);
  logic         primed_q;
  logic         und_q;
  logic         sv_q;
  logic [W-1:0] sd_q;
  slot_act_e    act;

  // Release is allowed once the ring has been full, including the cycle it first is
  always_comb begin
    act = SLOT_IDLE;
    if (en && slot_req) begin
      if (!(primed_q || full)) act = SLOT_PREFILL;
      else if (empty)          act = SLOT_UNDERRUN;
      else                     act = SLOT_SERVE;
    end
  end

  assign in_ready   = en && !full;
  assign ring_push  = in_valid && in_ready;
  assign ring_wdata = in_data;
  assign ring_pop   = (act == SLOT_SERVE);
  assign ring_flush = !en;
  assign dma_req    = in_ready && !(halt_en && und_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      primed_q <= 1'b0;
      und_q    <= 1'b0;
      sv_q     <= 1'b0;
      sd_q     <= '0;
    end else begin
      if (full) primed_q <= 1'b1;
      if (act == SLOT_UNDERRUN) und_q <= 1'b1;
      if (slot_req) begin
        if (act == SLOT_SERVE) begin
          sv_q <= 1'b1;
          sd_q <= head;
        end else begin
          sv_q <= 1'b0;
          sd_q <= '0;
        end
      end
    end
  end

  assign slot_valid = sv_q;
  assign slot_data  = sd_q;
  assign underrun   = und_q;

endmodule

// File: rtl/asf_rx_path.sv
`timescale 1ns/1ps
module asf_rx_path #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         halt_en,
  input  logic         strobe,
  input  logic [W-1:0] strobe_data,
  input  logic         out_ready,
  input  logic [W-1:0] head,
  input  logic         empty,
  input  logic         full,
  output logic         ring_push,
  output logic [W-1:0] ring_wdata,
  output logic         ring_pop,
  output logic         ring_flush,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         dma_req,
  output logic         overrun
);
  logic ovr_q;
  logic take;

  // A strobe on a full ring is lost even if a beat drains this cycle
  assign take       = en && strobe;
  assign ring_push  = take && !full;
  assign ring_wdata = strobe_data;
  assign ring_flush = !en;
  assign out_valid  = en && !empty;
  assign out_data   = head;
  assign ring_pop   = out_valid && out_ready;
  assign dma_req    = out_valid && !(halt_en && ovr_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ovr_q <= 1'b0;
    end else if (take && full) begin
      ovr_q <= 1'b1;
    end
  end

  assign overrun = ovr_q;

endmodule

// File: rtl/audio_sample_fifo.sv
`timescale 1ns/1ps
module audio_sample_fifo #(
  parameter int unsigned W        = 20,
  parameter int unsigned TX_DEPTH = 3,
  parameter int unsigned RX_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         tx_halt_en,
  input  logic         tx_in_valid,
  output logic         tx_in_ready,
  input  logic [W-1:0] tx_in_data,
  output logic         tx_dma_req,
  input  logic         tx_slot_req,
  output logic         tx_slot_valid,
  output logic [W-1:0] tx_slot_data,
  output logic         tx_underrun,
  input  logic         rx_en,
  input  logic         rx_halt_en,
  input  logic         rx_strobe,
  input  logic [W-1:0] rx_strobe_data,
  output logic         rx_out_valid,
  input  logic         rx_out_ready,
  output logic [W-1:0] rx_out_data,
  output logic         rx_dma_req,
  output logic         rx_overrun
);
  logic         txr_push, txr_pop, txr_flush, txr_empty, txr_full;
  logic [W-1:0] txr_wdata, txr_head;
  logic         rxr_push, rxr_pop, rxr_flush, rxr_empty, rxr_full;
  logic [W-1:0] rxr_wdata, rxr_head;

  asf_sample_ring #(.DEPTH(TX_DEPTH), .W(W)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .flush(txr_flush),
    .push(txr_push), .push_data(txr_wdata), .pop(txr_pop),
    .head(txr_head), .empty(txr_empty), .full(txr_full)
  );

  asf_tx_path #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .halt_en(tx_halt_en),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .slot_req(tx_slot_req),
    .head(txr_head), .empty(txr_empty), .full(txr_full),
    .ring_push(txr_push), .ring_wdata(txr_wdata), .ring_pop(txr_pop),
    .ring_flush(txr_flush), .in_ready(tx_in_ready), .dma_req(tx_dma_req),
    .slot_valid(tx_slot_valid), .slot_data(tx_slot_data), .underrun(tx_underrun)
  );

  asf_sample_ring #(.DEPTH(RX_DEPTH), .W(W)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .flush(rxr_flush),
    .push(rxr_push), .push_data(rxr_wdata), .pop(rxr_pop),
    .head(rxr_head), .empty(rxr_empty), .full(rxr_full)
  );

  asf_rx_path #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .halt_en(rx_halt_en),
    .strobe(rx_strobe), .strobe_data(rx_strobe_data), .out_ready(rx_out_ready),
    .head(rxr_head), .empty(rxr_empty), .full(rxr_full),
    .ring_push(rxr_push), .ring_wdata(rxr_wdata), .ring_pop(rxr_pop),
    .ring_flush(rxr_flush), .out_valid(rx_out_valid), .out_data(rx_out_data),
    .dma_req(rx_dma_req), .overrun(rx_overrun)
  );

endmodule

// File: rtl/audio_sample_fifo_chk.sv
`timescale 1ns/1ps
module audio_sample_fifo_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_en,
  input logic         tx_halt_en,
  input logic         tx_in_ready,
  input logic         tx_dma_req,
  input logic         tx_slot_valid,
  input logic [W-1:0] tx_slot_data,
  input logic         tx_underrun,
  input logic         rx_en,
  input logic         rx_halt_en,
  input logic         rx_out_valid,
  input logic         rx_dma_req,
  input logic         rx_overrun
);

  // R1
  tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (tx_en && tx_in_ready));

  // R2
  tx_data_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot_data != '0) |-> tx_slot_valid);

  // R4
  tx_und_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> (!tx_slot_valid && tx_slot_data == '0));

  // R4
  tx_und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_underrun) |=> tx_underrun);

  // R8
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!tx_underrun && !tx_slot_valid));

  // R9
  tx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halt_en && tx_underrun) |-> !tx_dma_req);

  // R5
  rx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> rx_out_valid);

  // R7
  rx_ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_overrun) |=> rx_overrun);

  // R8
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_overrun && !rx_out_valid));

  // R9
  rx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt_en && rx_overrun) |-> !rx_dma_req);

endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_en(tx_en), .tx_halt_en(tx_halt_en), .tx_in_ready(tx_in_ready),
  .tx_dma_req(tx_dma_req), .tx_slot_valid(tx_slot_valid),
  .tx_slot_data(tx_slot_data), .tx_underrun(tx_underrun),
  .rx_en(rx_en), .rx_halt_en(rx_halt_en), .rx_out_valid(rx_out_valid),
  .rx_dma_req(rx_dma_req), .rx_overrun(rx_overrun)
);

// File: tb/tb_audio_sample_fifo.sv
`timescale 1ns/100ps
module tb_audio_sample_fifo;
  localparam int unsigned W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, tx_halt_en = 0, tx_in_valid = 0, tx_slot_req = 0;
  logic [W-1:0] tx_in_data = '0;
  logic rx_en = 0, rx_halt_en = 0, rx_strobe = 0, rx_out_ready = 0;
  logic [W-1:0] rx_strobe_data = '0;
  logic tx_in_ready, tx_dma_req, tx_slot_valid, tx_underrun;
  logic [W-1:0] tx_slot_data, rx_out_data;
  logic rx_out_valid, rx_dma_req, rx_overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_sample_fifo #(.W(W), .TX_DEPTH(3), .RX_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_halt_en(tx_halt_en), .tx_in_valid(tx_in_valid),
    .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data), .tx_dma_req(tx_dma_req),
    .tx_slot_req(tx_slot_req), .tx_slot_valid(tx_slot_valid),
    .tx_slot_data(tx_slot_data), .tx_underrun(tx_underrun),
    .rx_en(rx_en), .rx_halt_en(rx_halt_en), .rx_strobe(rx_strobe),
    .rx_strobe_data(rx_strobe_data), .rx_out_valid(rx_out_valid),
    .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_dma_req(rx_dma_req), .rx_overrun(rx_overrun)
  );

  typedef struct packed {
    logic         en;
    logic         iv;
    logic [W-1:0] d;
    logic         rq;
    logic         e_rdy;
    logic         e_dreq;
    logic         e_val;
    logic [W-1:0] e_dat;
    logic         e_und;
  } txv_t;

  // Transmit walk, depth 3, halt off. R1 R2 R3 R4 R8 R11
  localparam txv_t TXV [14] = '{
    '{1'b0, 1'b0, 20'h0,     1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b1, 20'h00A01, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b1, 20'h00A02, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b1, 20'h00A03, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b1, 20'h00A04, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b0, 20'h0,     1'b1, 1'b0, 1'b0, 1'b1, 20'h00A01, 1'b0},
    '{1'b1, 1'b1, 20'h00A05, 1'b1, 1'b1, 1'b1, 1'b1, 20'h00A02, 1'b0},
    '{1'b1, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 1'b1, 20'h00A03, 1'b0},
    '{1'b1, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 1'b1, 20'h00A05, 1'b0},
    '{1'b1, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     1'b1},
    '{1'b1, 1'b1, 20'h00A06, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     1'b1},
    '{1'b1, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 1'b1, 20'h00A06, 1'b1},
    '{1'b0, 1'b0, 20'h0,     1'b0, 1'b0, 1'b0, 1'b0, 20'h0,     1'b0},
    '{1'b1, 1'b1, 20'h00A07, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R10 reset state
    chk("R10 tx_in_ready",   32'(tx_in_ready),   0);
    chk("R10 tx_dma_req",    32'(tx_dma_req),    0);
    chk("R10 tx_slot_valid", 32'(tx_slot_valid), 0);
    chk("R10 tx_slot_data",  32'(tx_slot_data),  0);
    chk("R10 tx_underrun",   32'(tx_underrun),   0);
    chk("R10 rx_out_valid",  32'(rx_out_valid),  0);
    chk("R10 rx_dma_req",    32'(rx_dma_req),    0);
    chk("R10 rx_overrun",    32'(rx_overrun),    0);

    // Vector walk: R1 R2 R3 R4 R8 R11
    for (int v = 0; v < 14; v++) begin
      @(negedge clk);
      tx_en       = TXV[v].en;
      tx_in_valid = TXV[v].iv;
      tx_in_data  = TXV[v].d;
      tx_slot_req = TXV[v].rq;
      #0.5;
      chk($sformatf("vec %0d R1 tx_in_ready", v), 32'(tx_in_ready), 32'(TXV[v].e_rdy));
      chk($sformatf("vec %0d R1 tx_dma_req", v),  32'(tx_dma_req),  32'(TXV[v].e_dreq));
      @(posedge clk);
      #0.5;
      chk($sformatf("vec %0d R2 R3 R11 slot_valid", v), 32'(tx_slot_valid), 32'(TXV[v].e_val));
      chk($sformatf("vec %0d R2 R4 slot_data", v),      32'(tx_slot_data),  32'(TXV[v].e_dat));
      chk($sformatf("vec %0d R4 R8 underrun", v),       32'(tx_underrun),   32'(TXV[v].e_und));
    end

    // R9 transmit error-halt
    @(negedge clk);
    tx_en = 0; tx_in_valid = 0; tx_slot_req = 0;
    cyc();
    tx_en = 1; tx_halt_en = 1;
    for (int i = 0; i < 3; i++) begin
      tx_in_valid = 1; tx_in_data = 20'h00C00 + W'(i);
      cyc();
    end
    tx_in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      tx_slot_req = 1;
      cyc();
      chk("R2 halt-run slot_data", 32'(tx_slot_data), 32'(20'h00C00 + i));
    end
    cyc();
    chk("R4 underrun after drain", 32'(tx_underrun), 1);
    chk("R9 tx_dma_req halted", 32'(tx_dma_req), 0);
    chk("R9 tx_in_ready still high", 32'(tx_in_ready), 1);
    tx_slot_req = 0; tx_halt_en = 0;
    #0.5;
    chk("R9 tx_dma_req with halt off", 32'(tx_dma_req), 1);
    tx_en = 0;
    cyc();
    tx_en = 1;
    cyc();
    chk("R8 underrun cleared by toggle", 32'(tx_underrun), 0);

    // R6 strobe while disabled
    rx_en = 0; rx_strobe = 1; rx_strobe_data = 20'h00B00;
    cyc();
    rx_strobe = 0; rx_en = 1;
    #0.5;
    chk("R6 nothing stored while disabled", 32'(rx_out_valid), 0);
    cyc();
    rx_strobe = 1; rx_strobe_data = 20'h00B01;
    cyc();
    chk("R5 rx_out_valid", 32'(rx_out_valid), 1);
    chk("R5 rx_out_data",  32'(rx_out_data),  32'(20'h00B01));
    chk("R5 rx_dma_req",   32'(rx_dma_req),   1);
    rx_strobe_data = 20'h00B02;
    cyc();
    rx_strobe_data = 20'h00B03;
    cyc();
    chk("R7 overrun on full", 32'(rx_overrun), 1);
    chk("R7 head unchanged", 32'(rx_out_data), 32'(20'h00B01));
    rx_strobe = 0; rx_out_ready = 1;
    cyc();
    chk("R5 second beat", 32'(rx_out_data), 32'(20'h00B02));
    cyc();
    chk("R7 dropped sample absent", 32'(rx_out_valid), 0);
    chk("R5 no request when empty", 32'(rx_dma_req), 0);
    chk("R7 overrun sticky", 32'(rx_overrun), 1);
    rx_out_ready = 0;
    rx_strobe = 1; rx_strobe_data = 20'h00B04;
    cyc();
    rx_strobe_data = 20'h00B05;
    cyc();
    rx_strobe_data = 20'h00B06; rx_out_ready = 1;
    cyc();
    rx_strobe = 0; rx_out_ready = 0;
    #0.5;
    chk("R7 full plus pop drops strobe: head", 32'(rx_out_data), 32'(20'h00B05));
    rx_out_ready = 1;
    cyc();
    rx_out_ready = 0;
    #0.5;
    chk("R7 full plus pop drops strobe: empty", 32'(rx_out_valid), 0);
    rx_strobe = 1; rx_strobe_data = 20'h00B07;
    cyc();
    rx_strobe = 0; rx_halt_en = 1;
    #0.5;
    chk("R9 rx halted request", 32'(rx_dma_req), 0);
    chk("R9 rx data still offered", 32'(rx_out_valid), 1);
    rx_halt_en = 0;
    #0.5;
    chk("R9 rx request with halt off", 32'(rx_dma_req), 1);
    rx_en = 0;
    cyc();
    rx_en = 1;
    #0.5;
    chk("R8 rx overrun cleared", 32'(rx_overrun), 0);
    chk("R8 rx flushed", 32'(rx_out_valid), 0);

    finish_run();
  end

endmodule